// File: doc/BRIEF.md
# Dual-Clock FIFO with Mode-Dependent Flags

This block buffers 18-bit words between two unrelated clock domains. A producer writes on its own clock and a consumer reads on a second clock. The storage depth is a power of two and is set by a parameter. Each side keeps its own binary pointer. It converts the pointer to Gray code and passes it through a two-flop synchronizer to the other side. The full-side flag is therefore computed on the write clock, and the empty-side flag on the read clock.

A mode input is sampled while master reset is low. It selects one of two read styles:

- **Standard mode.** A word is fetched only when the consumer asks for it. The two flags are active-low "full" and "empty" indications.
- **Fall-through mode.** The oldest word is moved into an output holding register without being asked. The same two pins then carry active-high "cannot accept" and active-low "word present" indications. The held word counts toward capacity, so this mode stores one word more than standard mode.

A second strap, sampled together with the mode, picks the reset value of two offset registers. These registers are visible as outputs. There are two resets. The master reset empties the FIFO and captures the straps. The partial reset only empties the FIFO.

Top module: `dcfifo_dualmode`

## Requirements
- R1: After master reset in standard mode, `full_ir` is 1 and `empty_or` is 0. After master reset in fall-through mode, `full_ir` is 0 and `empty_or` is 1. After any reset, `dout` is 0.
- R2: In standard mode with no reads, `full_ir` stays 1 through the first DEPTH-1 writes. It reads 0 at the first write-clock sample after write number DEPTH. A write issued while `full_ir` is 0 is dropped: the words read out afterwards are only the first DEPTH words, in order.
- R3: In fall-through mode, with the first word already moved to the output register, `full_ir` stays 0 until DEPTH further words have been written, and then reads 1. A write issued while `full_ir` is 1 is dropped: exactly DEPTH+1 words come out, in order.
- R4: In standard mode, `empty_or` is 0 whenever no word is stored. A read request while `empty_or` is 0 leaves `dout` unchanged.
- R5: In standard mode, an accepted read puts the oldest stored word on `dout` at the read-clock edge that accepts it. Words leave in the order they were written.
- R6: In fall-through mode, `empty_or` falls on the same read-clock edge that the word appears on `dout`. While `empty_or` is 0, a read request moves the next word onto `dout`. After the last word is consumed, `empty_or` reads 1 on the edge that consumes it. While `empty_or` is 1, read requests leave `dout` unchanged.
- R7: Consider a write into an empty FIFO, with clock edges that never coincide. In standard mode, `empty_or` rises on the 2nd rising read-clock edge after the write edge. In fall-through mode, `empty_or` falls on the 3rd such edge, one read clock later than in standard mode.
- R8: A pulse on `prst_n` empties the FIFO and returns both flags to their reset polarity for the current mode. It does not change the mode or the offset outputs.
- R9: The offset outputs `full_offset` and `empty_offset` reset to 0x07F when `load_sel` is 0 at master reset, and to 0x3FF when `load_sel` is 1. Both values are masked to OFFS_W bits, so with the default width the second value appears as 0x0FF.
- R10: `fwft_sel` is captured only while `mrst_n` is low. Changing it at any other time has no effect on flag polarity or behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; empties the FIFO and captures the straps |
| prst_n | input | 1 | Partial reset, active low; empties the FIFO only |
| fwft_sel | input | 1 | Mode strap: 0 selects standard mode, 1 selects fall-through mode |
| load_sel | input | 1 | Offset default strap: 0 selects 0x07F, 1 selects 0x3FF |
| wr_en | input | 1 | Write request (write clock) |
| din | input | DATA_W | Write data |
| full_ir | output | 1 | Standard mode: full, active low. Fall-through mode: cannot accept, active high |
| rd_en | input | 1 | Read request (read clock) |
| dout | output | DATA_W | Read data or held output word |
| empty_or | output | 1 | Standard mode: empty, active low. Fall-through mode: word present, active low |
| full_offset | output | OFFS_W | Full-side offset register value |
| empty_offset | output | OFFS_W | Empty-side offset register value |

## Verification
The bench builds the block with its defaults: 18-bit data, ADDR_W of 4 (sixteen words) and 8-bit offsets. The small depth means a fill to the flag boundary, with the extra word in fall-through mode, and a complete drain both fit in a few hundred cycles. The two clocks have the same period but are offset by a fixed phase. This gives a known number of read edges after each write edge, so the two- and three-edge first-word latencies can be counted exactly. The 8-bit offset width leaves the 0x07F default intact but visibly truncates 0x3FF, so the strap choice and the masking are both observable.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  // Binary to reflected Gray code.
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray code back to binary, MSB first.
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Full: the two Gray pointers of width pw differ exactly in their top two bits.
  function automatic logic ptr_full(input logic [31:0] wg, input logic [31:0] rg,
                                    input int unsigned pw);
    return (wg ^ rg) == (32'h3 << (pw - 2));
  endfunction

  // Empty: the two Gray pointers are identical.
  function automatic logic ptr_empty(input logic [31:0] a, input logic [31:0] b);
    return a == b;
  endfunction

  // Reset value of an offset register, masked to its width.
  function automatic logic [31:0] offset_default(input logic load, input int unsigned ow);
    logic [31:0] v;
    v = load ? 32'h0000_03FF : 32'h0000_007F;
    return v & ((32'h1 << ow) - 32'h1);
  endfunction

endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/dcfifo_cfg.sv
module dcfifo_cfg
  import dcfifo_pkg::*;
#(
  parameter int unsigned OFFS_W = 8
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              load_in,
  output logic [OFFS_W-1:0] full_off,
  output logic [OFFS_W-1:0] empty_off
);

  logic [OFFS_W-1:0] dflt;
  assign dflt = OFFS_W'(offset_default(load_in, OFFS_W));

  // Straps are followed only while master reset is held.
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      full_off  <= dflt;
      empty_off <= dflt;
    end
  end

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> ($stable(full_off) && $stable(empty_off)))
    else $error("offset changed outside master reset"); // R8

endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst_n,
  input  logic              mode_in,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rgray_in,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              wr_accept,
  output logic              full_ir
);

  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  rd_mode_e          mode_q;
  logic [PTR_W-1:0]  wbin;
  logic [PTR_W-1:0]  wbin_nxt;
  logic [PTR_W-1:0]  rq2_gray;
  logic [PTR_W-1:0]  rq2_bin;
  logic              mem_full;

  always_ff @(posedge clk) begin
    if (!mrst_n) mode_q <= rd_mode_e'(mode_in);
  end

  dcfifo_sync2 #(.W(PTR_W)) u_rsync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rgray_in),
    .q     (rq2_gray)
  );

  assign rq2_bin   = PTR_W'(gray2bin(32'(rq2_gray)));
  assign mem_full  = ptr_full(32'(wgray), 32'(rq2_gray), PTR_W);
  assign wr_accept = wr_en & ~mem_full;
  assign wbin_nxt  = wbin + PTR_W'(1);
  assign waddr     = wbin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_accept) begin
      wbin  <= wbin_nxt;
      wgray <= PTR_W'(bin2gray(32'(wbin_nxt)));
    end
  end

  // Same pin, opposite sense per mode.
  assign full_ir = (mode_q == MODE_FWFT) ? mem_full : ~mem_full;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |=> (wbin == $past(wbin)))
    else $error("write pointer moved while full"); // R2

  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (PTR_W'(wbin - rq2_bin) <= PTR_W'(DEPTH)))
    else $error("write side sees more than DEPTH words"); // R3

  AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)))
    else $error("write Gray pointer changed in more than one bit"); // R7

endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst_n,
  input  logic              mode_in,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wgray_in,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] dout,
  output logic              empty_or
);

  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  rd_mode_e          mode_q;
  logic [PTR_W-1:0]  rbin;
  logic [PTR_W-1:0]  rbin_nxt;
  logic [PTR_W-1:0]  wq2_gray;
  logic [PTR_W-1:0]  wq2_bin;
  logic              mem_empty;
  logic              ovalid;
  logic              rd_take;
  logic              consume;
  logic              fwft;

  always_ff @(posedge clk) begin
    if (!mrst_n) mode_q <= rd_mode_e'(mode_in);
  end

  assign fwft = (mode_q == MODE_FWFT);

  dcfifo_sync2 #(.W(PTR_W)) u_wsync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (wgray_in),
    .q     (wq2_gray)
  );

  assign wq2_bin   = PTR_W'(gray2bin(32'(wq2_gray)));
  assign mem_empty = ptr_empty(32'(rgray), 32'(wq2_gray));
  assign rbin_nxt  = rbin + PTR_W'(1);
  assign raddr     = rbin[ADDR_W-1:0];

  // Fetch from memory: on request in standard mode, on its own in fall-through mode.
  always_comb begin
    consume = fwft & ovalid & rd_en;
    if (fwft) rd_take = ~mem_empty & (~ovalid | rd_en);
    else      rd_take = ~mem_empty & rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      dout   <= '0;
      ovalid <= 1'b0;
    end else begin
      if (rd_take) begin
        rbin  <= rbin_nxt;
        rgray <= PTR_W'(bin2gray(32'(rbin_nxt)));
        dout  <= rdata;
      end
      ovalid <= fwft & (rd_take | (ovalid & ~consume));
    end
  end

  assign empty_or = fwft ? ~ovalid : ~mem_empty;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && mem_empty) |=> (rbin == $past(rbin)))
    else $error("read pointer moved while empty"); // R4

  AST_FWFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && ovalid && !rd_en) |=> (ovalid && $stable(dout)))
    else $error("held word lost without a read"); // R6

  AST_DRAIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (PTR_W'(wq2_bin - rbin) <= PTR_W'(DEPTH)))
    else $error("read side sees more than DEPTH words"); // R5

  AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)))
    else $error("read Gray pointer changed in more than one bit"); // R7

endmodule

// File: rtl/dcfifo_dualmode.sv
module dcfifo_dualmode #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned OFFS_W = 8
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fwft_sel,
  input  logic              load_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  output logic              full_ir,
  input  logic              rd_en,
  output logic [DATA_W-1:0] dout,
  output logic              empty_or,
  output logic [OFFS_W-1:0] full_offset,
  output logic [OFFS_W-1:0] empty_offset
);

  localparam int unsigned PTR_W = ADDR_W + 1;

  logic              fifo_rst_n;
  logic [PTR_W-1:0]  wgray;
  logic [PTR_W-1:0]  rgray;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;
  logic              wr_accept;

  // Either reset empties the FIFO; only master reset reloads straps.
  assign fifo_rst_n = mrst_n & prst_n;

  dcfifo_cfg #(.OFFS_W(OFFS_W)) u_cfg (
    .clk       (wclk),
    .mrst_n    (mrst_n),
    .load_in   (load_sel),
    .full_off  (full_offset),
    .empty_off (empty_offset)
  );

  dcfifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk       (wclk),
    .rst_n     (fifo_rst_n),
    .mrst_n    (mrst_n),
    .mode_in   (fwft_sel),
    .wr_en     (wr_en),
    .rgray_in  (rgray),
    .wgray     (wgray),
    .waddr     (waddr),
    .wr_accept (wr_accept),
    .full_ir   (full_ir)
  );

  dcfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk  (wclk),
    .we    (wr_accept),
    .waddr (waddr),
    .wdata (din),
    .raddr (raddr),
    .rdata (rdata)
  );

  dcfifo_rd_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk      (rclk),
    .rst_n    (fifo_rst_n),
    .mrst_n   (mrst_n),
    .mode_in  (fwft_sel),
    .rd_en    (rd_en),
    .wgray_in (wgray),
    .rdata    (rdata),
    .rgray    (rgray),
    .raddr    (raddr),
    .dout     (dout),
    .empty_or (empty_or)
  );

endmodule

// File: tb/dcfifo_dualmode_tb.sv
module dcfifo_dualmode_tb;

  localparam int DATA_W = 18;
  localparam int ADDR_W = 4;
  localparam int OFFS_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [DATA_W-1:0] VEC [8] = '{
    18'h00000, 18'h3FFFF, 18'h15555, 18'h2AAAA,
    18'h00001, 18'h20000, 18'h1F0F0, 18'h0C3C3
  };

  logic              wclk = 1'b0;
  logic              rclk = 1'b0;
  logic              mrst_n = 1'b0;
  logic              prst_n = 1'b1;
  logic              fwft_sel = 1'b0;
  logic              load_sel = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic              rd_en = 1'b0;
  logic              full_ir;
  logic              empty_or;
  logic [DATA_W-1:0] dout;
  logic [OFFS_W-1:0] full_offset;
  logic [OFFS_W-1:0] empty_offset;

  int checks = 0;
  int fails  = 0;

  dcfifo_dualmode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_dut (
    .wclk, .rclk, .mrst_n, .prst_n, .fwft_sel, .load_sel,
    .wr_en, .din, .full_ir, .rd_en, .dout, .empty_or,
    .full_offset, .empty_offset
  );

  // 50 MHz on both sides; read clock lags by 7 ns.
  always #10 wclk = ~wclk;
  initial begin
    #7;
    forever #10 rclk = ~rclk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic master_reset(input logic m, input logic l);
    @(negedge wclk);
    fwft_sel = m;
    load_sel = l;
    mrst_n   = 1'b0;
    repeat (4) @(negedge wclk);
    mrst_n = 1'b1;
    repeat (3) @(negedge wclk);
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1;
    din   = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  // Returns the count of read edges after the write edge until empty_or leaves idle_val.
  task automatic timed_write(input logic [DATA_W-1:0] d, input logic idle_val, output int n);
    @(negedge wclk);
    wr_en = 1'b1;
    din   = d;
    @(posedge wclk);
    #1 wr_en = 1'b0;
    n = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge rclk);
      #1;
      if (empty_or != idle_val) begin
        n = k;
        break;
      end
    end
  endtask

  initial begin
    #(100000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    logic [DATA_W-1:0] hold;

    // ---------------- standard mode, load strap low ----------------
    master_reset(1'b0, 1'b0);
    chk("R1 std full_ir after reset", full_ir, 1);
    chk("R1 std empty_or after reset", empty_or, 0);
    chk("R1 dout after reset", dout, 0);
    chk("R9 full_offset strap0", full_offset, 8'h7F);
    chk("R9 empty_offset strap0", empty_offset, 8'h7F);

    pop();
    chk("R4 read while empty keeps dout", dout, 0);
    chk("R4 empty_or still low", empty_or, 0);

    // Table walk: every vector written, then read back in order.
    foreach (VEC[i]) push(VEC[i]);
    repeat (4) @(negedge rclk);
    chk("R4 empty_or high with data", empty_or, 1);
    foreach (VEC[i]) begin
      pop();
      chk($sformatf("R5 table word %0d", i), dout, VEC[i]);
    end
    repeat (4) @(negedge rclk);
    chk("R4 empty_or low after drain", empty_or, 0);
    hold = dout;
    pop();
    chk("R4 read on empty leaves dout", dout, hold);

    timed_write(18'h12345, 1'b0, n);
    chk("R7 std first-word latency edges", n, 2);
    pop();
    chk("R5 latency word data", dout, 18'h12345);

    // Fill to the boundary.
    master_reset(1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) chk("R2 not full before last write", full_ir, 1);
      push(DATA_W'(18'h00100 + i));
    end
    chk("R2 full after DEPTH writes", full_ir, 0);
    push(18'h3BEEF);
    chk("R2 still full after dropped write", full_ir, 0);
    repeat (4) @(negedge rclk);
    for (int i = 0; i < DEPTH; i++) begin
      pop();
      if (dout !== DATA_W'(18'h00100 + i))
        chk($sformatf("R2 drained word %0d", i), dout, DATA_W'(18'h00100 + i));
    end
    chk("R2 last drained word", dout, DATA_W'(18'h00100 + DEPTH - 1));
    repeat (4) @(negedge rclk);
    chk("R2 dropped write never stored", empty_or, 0);
    repeat (4) @(negedge wclk);
    chk("R2 full released after drain", full_ir, 1);

    // ---------------- fall-through mode, load strap high ----------------
    master_reset(1'b1, 1'b1);
    chk("R1 fwft full_ir after reset", full_ir, 0);
    chk("R1 fwft empty_or after reset", empty_or, 1);
    chk("R9 full_offset strap1 masked", full_offset, 8'hFF);
    chk("R9 empty_offset strap1 masked", empty_offset, 8'hFF);

    fwft_sel = 1'b0;
    repeat (4) @(negedge wclk);
    chk("R10 mode kept full_ir", full_ir, 0);
    chk("R10 mode kept empty_or", empty_or, 1);

    timed_write(18'h2C0DE, 1'b1, n);
    chk("R7 fwft first-word latency edges", n, 3);
    chk("R6 word valid as empty_or falls", dout, 18'h2C0DE);

    push(18'h00011);
    push(18'h00022);
    push(18'h00033);
    repeat (6) @(negedge rclk);
    chk("R6 head held without read", dout, 18'h2C0DE);
    pop();
    chk("R6 read advances to word 2", dout, 18'h00011);
    pop();
    chk("R6 read advances to word 3", dout, 18'h00022);
    pop();
    chk("R6 read advances to word 4", dout, 18'h00033);
    chk("R6 empty_or low with last word", empty_or, 0);
    pop();
    chk("R6 empty_or high after last consumed", empty_or, 1);
    hold = dout;
    pop();
    chk("R6 read with empty_or high keeps dout", dout, hold);

    // Capacity of DEPTH+1 words.
    master_reset(1'b1, 1'b1);
    push(18'h30000);
    repeat (8) @(negedge rclk);
    repeat (4) @(negedge wclk);
    for (int i = 1; i <= DEPTH; i++) begin
      if (i == DEPTH) chk("R3 ready before last write", full_ir, 0);
      push(DATA_W'(18'h30000 + i));
    end
    chk("R3 blocked after DEPTH+1 writes", full_ir, 1);
    push(18'h0DEAD);
    repeat (4) @(negedge rclk);
    for (int i = 0; i <= DEPTH; i++) begin
      if (dout !== DATA_W'(18'h30000 + i))
        chk($sformatf("R3 word %0d", i), dout, DATA_W'(18'h30000 + i));
      pop();
    end
    repeat (6) @(negedge rclk);
    chk("R3 exactly DEPTH+1 words stored", empty_or, 1);

    // Partial reset keeps mode and offsets.
    push(18'h0AAAA);
    push(18'h0BBBB);
    repeat (8) @(negedge rclk);
    chk("R8 data present before partial reset", empty_or, 0);
    @(negedge wclk);
    prst_n = 1'b0;
    repeat (3) @(negedge wclk);
    prst_n = 1'b1;
    repeat (2) @(negedge wclk);
    chk("R8 empty_or after partial reset", empty_or, 1);
    chk("R8 full_ir after partial reset", full_ir, 0);
    chk("R8 dout cleared", dout, 0);
    chk("R8 offsets kept", full_offset, 8'hFF);
    push(18'h0CCCC);
    repeat (8) @(negedge rclk);
    chk("R8 fall-through mode kept", empty_or, 0);
    chk("R8 old words discarded", dout, 18'h0CCCC);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule